// File: doc/BRIEF.md
# Snoopy MESI Coherence Line Controller

This block keeps the coherence state of every line of one private cache in a multi-core system. The cores share a single bus and keep their caches coherent by write-invalidate snooping. A processor read or write names a line. The controller decides from that line's state whether a bus transaction is needed. When one is, it requests the bus, holds the command until the arbiter grants it, and then installs the new state. It also watches every transaction that other caches put on the bus. It answers with a shared indication and a flush request, and it downgrades or invalidates its own copy.

A mode input chooses between three-state MSI behaviour and four-state MESI behaviour. In MESI mode, a read fill that no other cache answers as shared lands in Exclusive. A later write to that line then becomes Modified silently. Counting bus requests under both modes for the same access stream shows the traffic that the Exclusive state saves. The state of any line can be observed on the state output by placing its index on the processor line input.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (encoding Invalid=0, Shared=1, Exclusive=2, Modified=3), no bus request is raised and the processor side is ready.
- R2: A processor read of an Invalid line raises a bus request with command read (busCmd=0). At the grant the line fills as Exclusive when MESI mode is on and busSharedIn is low, and as Shared otherwise.
- R3: A processor write to an Invalid or Shared line raises a bus request with command read-exclusive (busCmd=1), and the line becomes Modified at the grant.
- R4: A processor write to an Exclusive or Modified line raises no bus request, and the line becomes or stays Modified.
- R5: A processor read of a Shared, Exclusive or Modified line raises no bus request and leaves the state unchanged.
- R6: A snooped read (snoopCmd=0) moves a Modified or Exclusive line to Shared and leaves a Shared line Shared. In the cycle after the snoop, snoopShared is high when the line was valid, and snoopFlush is high when the line was Modified.
- R7: A snooped read-exclusive (snoopCmd=1) makes the line Invalid. In the cycle after the snoop, snoopFlush is high when the line was Modified, and snoopShared is high when the line was valid.
- R8: A snoop of an Invalid line leaves it Invalid and drives neither snoopShared nor snoopFlush.
- R9: While a bus request is waiting, busReq stays high with a stable command until busGrant. cpuDone pulses for one cycle in the cycle after the grant, or in the cycle after acceptance when no bus transaction is needed.
- R10: cpuReady is low while a request is pending and in any cycle with a snoop. A request presented while cpuReady is low is not accepted.
- R11: In MSI mode no line ever reaches Exclusive. For a read then a write of each unshared line, MSI mode needs two bus transactions per line and MESI mode needs one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mesiMode | input | 1 | 1 selects MESI, 0 selects MSI |
| cpuReq | input | 1 | Processor request strobe |
| cpuWrite | input | 1 | 1 write, 0 read |
| cpuLine | input | IDX_W | Line index of the request, also selects the line shown on lineState |
| cpuReady | output | 1 | A request can be accepted this cycle |
| cpuDone | output | 1 | Request completed (one-cycle pulse) |
| lineState | output | 2 | Current state of the line chosen by cpuLine |
| busReq | output | 1 | Bus request |
| busCmd | output | 1 | 0 bus read, 1 bus read-exclusive |
| busGrant | input | 1 | Bus granted to this cache |
| busSharedIn | input | 1 | Another cache holds the line (sampled with the grant) |
| snoopValid | input | 1 | Another cache's transaction is on the bus |
| snoopCmd | input | 1 | 0 read, 1 read-exclusive |
| snoopLine | input | IDX_W | Line index of the snooped transaction |
| snoopShared | output | 1 | This cache held the snooped line |
| snoopFlush | output | 1 | This cache must supply dirty data |

## Verification
The hardest cases to reach are the silent Exclusive-to-Modified upgrade and the snooped downgrades of Exclusive and Modified lines. Each needs an earlier read fill that no other cache answered as shared, under MESI mode. The bench reaches them with a long pseudo-random stream that mixes processor accesses, snoops of both kinds and random shared answers on lines of a small cache. It tracks the expected state of every line in its own model. Grant delays also vary, so that a held request can be observed across several cycles.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2,
    ST_MOD = 2'd3
  } lineSt_e;

  localparam logic CMD_RD  = 1'b0;
  localparam logic CMD_RDX = 1'b1;

  localparam int MAX_IDX_W = 8;

  typedef struct packed {
    logic                 wrEn;
    logic [MAX_IDX_W-1:0] wrLine;
    lineSt_e              wrState;
  } strobe_t;
endpackage

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mesiMode,
  input  logic             cpuReq,
  input  logic             cpuWrite,
  input  logic [IDX_W-1:0] cpuLine,
  input  lineSt_e          cpuState,
  input  logic             snoopValid,
  input  logic             busGrant,
  input  logic             busSharedIn,
  output logic             cpuReady,
  output logic             cpuDone,
  output logic             busReq,
  output logic             busCmd,
  output strobe_t          strobe
);
  logic             waiting;
  logic [IDX_W-1:0] pendLine;
  logic             pendWrite;
  logic             pendCmd;
  logic             accept;
  logic             needBus;
  lineSt_e          fillState;
  lineSt_e          hitState;

  assign cpuReady = !waiting && !snoopValid;
  assign accept   = cpuReq && cpuReady;
  assign needBus  = cpuWrite ? (cpuState == ST_INV || cpuState == ST_SHR)
                             : (cpuState == ST_INV);
  assign hitState = cpuWrite ? ST_MOD : cpuState;
  assign fillState = pendWrite ? ST_MOD
                   : ((mesiMode && !busSharedIn) ? ST_EXC : ST_SHR);

  assign busReq = waiting;
  assign busCmd = pendCmd;

  always_comb begin
    strobe = '0;
    strobe.wrState = ST_INV;
    if (waiting && busGrant) begin
      strobe.wrEn    = 1'b1;
      strobe.wrLine  = MAX_IDX_W'(pendLine);
      strobe.wrState = fillState;
    end else if (accept && !needBus) begin
      strobe.wrEn    = 1'b1;
      strobe.wrLine  = MAX_IDX_W'(cpuLine);
      strobe.wrState = hitState;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waiting   <= 1'b0;
      pendLine  <= '0;
      pendWrite <= 1'b0;
      pendCmd   <= CMD_RD;
      cpuDone   <= 1'b0;
    end else begin
      cpuDone <= 1'b0;
      if (waiting) begin
        if (busGrant) begin
          waiting <= 1'b0;
          cpuDone <= 1'b1;
        end
      end else if (accept) begin
        if (needBus) begin
          waiting   <= 1'b1;
          pendLine  <= cpuLine;
          pendWrite <= cpuWrite;
          pendCmd   <= cpuWrite ? CMD_RDX : CMD_RD;
        end else begin
          cpuDone <= 1'b1;
        end
      end
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGrant) |=> (busReq && $stable(busCmd)));

  // R9
  done_after_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGrant) |=> (cpuDone && !busReq));

  // R10
  ready_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq || snoopValid) |-> !cpuReady);

  // R11
  msi_no_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !mesiMode) |-> (strobe.wrState != ST_EXC));

  // R9: the shared bus never carries another cache's transaction during our grant
  grant_snoop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busGrant && snoopValid));
endmodule

// File: rtl/mesi_lines.sv
module mesi_lines
  import mesi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [IDX_W-1:0] cpuLine,
  input  logic             snoopValid,
  input  logic             snoopCmd,
  input  logic [IDX_W-1:0] snoopLine,
  output lineSt_e          cpuState,
  output logic             snoopShared,
  output logic             snoopFlush
);
  lineSt_e stateArr [LINES];
  lineSt_e snpState;
  lineSt_e snpNext;

  assign cpuState = stateArr[cpuLine];
  assign snpState = stateArr[snoopLine];

  always_comb begin
    if (snoopCmd == CMD_RDX) snpNext = ST_INV;
    else if (snpState == ST_INV) snpNext = ST_INV;
    else snpNext = ST_SHR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) stateArr[i] <= ST_INV;
      snoopShared <= 1'b0;
      snoopFlush  <= 1'b0;
    end else begin
      snoopShared <= snoopValid && (snpState != ST_INV);
      snoopFlush  <= snoopValid && (snpState == ST_MOD);
      for (int i = 0; i < LINES; i++) begin
        if (snoopValid && snoopLine == IDX_W'(i))
          stateArr[i] <= snpNext;
        else if (strobe.wrEn && strobe.wrLine == MAX_IDX_W'(i))
          stateArr[i] <= strobe.wrState;
      end
    end
  end

  // R6
  flush_implies_shared_chk: assert property (@(posedge clk) disable iff (!rstN)
    snoopFlush |-> snoopShared);

  // R7
  rdx_invalidates_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && snoopCmd == CMD_RDX) |=> (stateArr[$past(snoopLine)] == ST_INV));

  // R8
  snoop_inv_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && snpState == ST_INV) |=> (!snoopShared && !snoopFlush));
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES = 4,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mesiMode,
  input  logic             cpuReq,
  input  logic             cpuWrite,
  input  logic [IDX_W-1:0] cpuLine,
  output logic             cpuReady,
  output logic             cpuDone,
  output logic [1:0]       lineState,
  output logic             busReq,
  output logic             busCmd,
  input  logic             busGrant,
  input  logic             busSharedIn,
  input  logic             snoopValid,
  input  logic             snoopCmd,
  input  logic [IDX_W-1:0] snoopLine,
  output logic             snoopShared,
  output logic             snoopFlush
);
  strobe_t strobe;
  lineSt_e cpuState;

  assign lineState = cpuState;

  mesi_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .mesiMode(mesiMode),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuLine(cpuLine),
    .cpuState(cpuState), .snoopValid(snoopValid),
    .busGrant(busGrant), .busSharedIn(busSharedIn),
    .cpuReady(cpuReady), .cpuDone(cpuDone),
    .busReq(busReq), .busCmd(busCmd), .strobe(strobe)
  );

  mesi_lines #(.LINES(LINES), .IDX_W(IDX_W)) uLines (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuLine(cpuLine),
    .snoopValid(snoopValid), .snoopCmd(snoopCmd), .snoopLine(snoopLine),
    .cpuState(cpuState), .snoopShared(snoopShared), .snoopFlush(snoopFlush)
  );
endmodule

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
  localparam int LINES = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mesiMode = 1'b0;
  logic cpuReq = 1'b0, cpuWrite = 1'b0;
  logic [IW-1:0] cpuLine = '0;
  logic cpuReady, cpuDone, busReq, busCmd, snoopShared, snoopFlush;
  logic [1:0] lineState;
  logic busGrant = 1'b0, busSharedIn = 1'b0;
  logic snoopValid = 1'b0, snoopCmd = 1'b0;
  logic [IW-1:0] snoopLine = '0;

  int tests = 0, fails = 0, busCount = 0;
  logic [1:0] model [LINES];
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  mesi_line_ctrl #(.LINES(LINES)) u0 (
    .clk(clk), .rstN(rstN), .mesiMode(mesiMode), .cpuReq(cpuReq),
    .cpuWrite(cpuWrite), .cpuLine(cpuLine), .cpuReady(cpuReady),
    .cpuDone(cpuDone), .lineState(lineState), .busReq(busReq),
    .busCmd(busCmd), .busGrant(busGrant), .busSharedIn(busSharedIn),
    .snoopValid(snoopValid), .snoopCmd(snoopCmd), .snoopLine(snoopLine),
    .snoopShared(snoopShared), .snoopFlush(snoopFlush)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < LINES; i++) model[i] = 2'd0;
    // R1 reset state
    check(!busReq && cpuReady && !cpuDone, "R1 idle", {busReq, cpuReady}, 1);
    for (int i = 0; i < LINES; i++) begin
      cpuLine = IW'(i);
      #1;
      check(lineState == 2'd0, "R1 invalid", lineState, 0);
    end
  endtask

  task automatic access(input int line, input bit wr, input bit sh, input int delay);
    bit expBus;
    logic [1:0] st;
    st = model[line];
    expBus = wr ? (st == 2'd0 || st == 2'd1) : (st == 2'd0);
    @(negedge clk);
    cpuLine = IW'(line);
    cpuWrite = wr;
    cpuReq = 1'b1;
    @(negedge clk);
    cpuReq = 1'b0;
    check(busReq == expBus, wr ? "R3/R4 bus need" : "R2/R5 bus need", busReq, expBus);
    if (busReq) begin
      busCount++;
      check(busCmd == wr, wr ? "R3 cmd" : "R2 cmd", busCmd, wr);
      // R10 request not accepted while pending
      check(!cpuReady, "R10 busy", cpuReady, 0);
      for (int d = 0; d < delay; d++) begin
        @(negedge clk);
        check(busReq && busCmd == wr && !cpuDone, "R9 hold", busReq, 1);
      end
      busGrant = 1'b1;
      busSharedIn = sh;
      @(negedge clk);
      busGrant = 1'b0;
      busSharedIn = 1'b0;
      if (wr) model[line] = 2'd3;
      else model[line] = (mesiMode && !sh) ? 2'd2 : 2'd1;
    end else begin
      if (wr) model[line] = 2'd3;
    end
    check(cpuDone == 1'b1 && !busReq, "R9 done", cpuDone, 1);
    check(lineState == model[line], wr ? "R3/R4 state" : "R2/R5 state",
          lineState, model[line]);
    check(!(mesiMode == 1'b0 && lineState == 2'd2), "R11 no E in MSI", lineState, 1);
    @(negedge clk);
    check(!cpuDone, "R9 pulse", cpuDone, 0);
  endtask

  task automatic snoop(input int line, input bit rdx);
    logic [1:0] st;
    st = model[line];
    @(negedge clk);
    snoopValid = 1'b1;
    snoopCmd = rdx;
    snoopLine = IW'(line);
    cpuReq = 1'b1;
    cpuWrite = 1'b1;
    cpuLine = IW'(line);
    #1;
    // R10 snoop blocks the processor side
    check(!cpuReady, "R10 snoop block", cpuReady, 0);
    @(negedge clk);
    snoopValid = 1'b0;
    cpuReq = 1'b0;
    if (rdx) model[line] = 2'd0;
    else if (st != 2'd0) model[line] = 2'd1;
    check(snoopShared == (st != 2'd0), rdx ? "R7 shared" : "R6 shared",
          snoopShared, st != 2'd0);
    check(snoopFlush == (st == 2'd3), st == 2'd0 ? "R8 flush" : "R6/R7 flush",
          snoopFlush, st == 2'd3);
    check(lineState == model[line], st == 2'd0 ? "R8 state" : (rdx ? "R7 state" : "R6 state"),
          lineState, model[line]);
    check(!busReq && !cpuDone, "R10 not accepted", cpuDone, 0);
  endtask

  initial begin
    doReset();
    for (int m = 0; m < 2; m++) begin
      mesiMode = m[0];
      doReset();
      for (int n = 0; n < 600; n++) begin
        logic [31:0] r;
        r = rnd();
        if (r[2:0] < 3'd2) snoop(int'(r[5:4]), r[6]);
        else access(int'(r[5:4]), r[7], r[8], int'(r[10:9]));
      end
    end
    // R11 bus traffic comparison
    for (int m = 0; m < 2; m++) begin
      mesiMode = m[0];
      doReset();
      busCount = 0;
      for (int l = 0; l < LINES; l++) begin
        access(l, 1'b0, 1'b0, 0);
        access(l, 1'b1, 1'b0, 1);
      end
      check(busCount == (m == 0 ? 2 * LINES : LINES), "R11 bus count",
            busCount, m == 0 ? 2 * LINES : LINES);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule